// File: doc/BRIEF.md
# Segmented Virtual Address Translator

The translator turns a 32-bit virtual address into a physical address. Bits 31..28 of the address select one of sixteen segments. Each segment is configured either as a linear segment or as a paged segment. A linear segment keeps the low 28 address bits and replaces the top nibble with a 4-bit base programmed for that segment. A paged segment produces no address itself. It raises a lookup request toward an external page-table engine, then waits for that engine to return a physical page number or to report a miss.

A request carries a privilege bit. User-mode requests are limited to the lower part of the address space, and any user access to segment B or above faults. The first 8 KiB page of the address space is never mapped. An access there through a paged segment faults without a lookup. Software controls the block through three plain load ports: one 16-bit mode word and two 32-bit words that together hold the sixteen segment bases. Out of reset every segment is a linear segment whose base equals its own index, so addresses map to themselves until software reprograms the block.

Results are registered. A linear or faulting result is presented one cycle after the request is accepted. A paged result is presented one cycle after the page-table engine responds. The block handles one paged lookup at a time and refuses new requests while that lookup is outstanding.

Top module: `seg_xlat`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A linear segment returns `res_paddr` = {base of segment, `req_vaddr[27:0]`} with `res_fault` low. The segment is `req_vaddr[31:28]`.
- R2: The base of segment s (0..7) is `base_lo[4s+3:4s]`. The base of segment s (8..15) is `base_hi[4(s-8)+3:4(s-8)]`, so segment F sits in `base_hi[31:28]`. A word is loaded when its write enable is high at a clock edge.
- R3: Bit s of the mode word sets the mapping of segment s. A 1 selects paged mapping and a 0 selects linear mapping. The word is loaded from `mode_wdata` when `mode_we` is high at a clock edge.
- R4: After reset the mode word is all zeros and every segment's base equals its own index, so every address translates to itself.
- R5: A request with `req_user` = 1 and segment >= B faults with `res_cause` = 1, whatever the segment's mode. A request with `req_user` = 0 is never limited this way.
- R6: A request that passes the R5 check, falls in a paged segment, and has an address below 0x2000 faults with `res_cause` = 2. Such a request raises no lookup.
- R7: Any other paged request raises `walk_req` on the cycle after acceptance, with `walk_vaddr` equal to the request address. Both hold steady and `req_ready` stays low until `walk_hit` or `walk_miss`. A `walk_hit` or `walk_miss` that arrives while no lookup is outstanding is ignored.
- R8: When `walk_hit` is high at an edge while `walk_req` is high, the next cycle gives `res_paddr` = {`walk_ppn`, `walk_vaddr[12:0]`} with no fault, and `walk_req` drops. Hit wins over a simultaneous miss.
- R9: When `walk_miss` alone is high at an edge while `walk_req` is high, the next cycle gives a fault with `res_cause` = 3.
- R10: `res_valid` is a one-cycle pulse per accepted request. On a fault, `res_paddr` is 0. Outside a result, `res_fault` is low and `res_cause` is 0. After reset `req_ready` is high and `res_valid`, `walk_req` are low.
- R11: A configuration load at the same edge as a request acceptance does not affect that request. It does affect every later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load the segment mode word |
| mode_wdata | input | 16 | Mode word; 1 = paged per segment |
| base_hi_we | input | 1 | Load the upper base word (segments F..8) |
| base_lo_we | input | 1 | Load the lower base word (segments 7..0) |
| base_wdata | input | 32 | Base word data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_fault | output | 1 | Result is a fault |
| res_cause | output | 2 | 0 none, 1 user ceiling, 2 null page, 3 lookup miss |
| walk_req | output | 1 | Paged lookup outstanding |
| walk_vaddr | output | 32 | Address under lookup |
| walk_hit | input | 1 | Lookup returned a page number |
| walk_ppn | input | 19 | Physical page number |
| walk_miss | input | 1 | Lookup found no mapping |

## Verification
The assertions assume the page-table engine responds only while `walk_req` is high. They also assume the engine's stray pulses at other times stay irrelevant, because the lookup checks are gated on `walk_req`. The bench breaks that assumption on purpose only to test R7's ignore rule. Even then it keeps `walk_ppn` stable across the response cycle. The stimulus never drives reset in the middle of a lookup. It sends requests only while the reference model shows no lookup outstanding, except in one case: a request held against a low `req_ready` to show that acceptance waits.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int VA_W        = 32;
    localparam int SEG_W       = 4;
    localparam int NUM_SEG     = 1 << SEG_W;
    localparam int PAGE_W      = 13;
    localparam int PPN_W       = VA_W - PAGE_W;
    localparam int OFS_W       = VA_W - SEG_W;
    localparam int CFG_W       = 32;
    localparam int SEG_PER_REG = CFG_W / SEG_W;

    localparam logic [SEG_W-1:0] USER_LIMIT_SEG = SEG_W'(11);

    typedef enum logic [1:0] {
        XK_LINEAR = 2'd0,
        XK_PAGED  = 2'd1,
        XK_FAULT  = 2'd2
    } xk_e;

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_CEILING = 2'd1,
        FC_NULLPG  = 2'd2,
        FC_MISS    = 2'd3
    } fcause_e;

    typedef struct packed {
        xk_e              kind;
        fcause_e          cause;
        logic [VA_W-1:0]  paddr;
    } xres_t;

    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_WAIT = 1'b1
    } pg_state_e;

    function automatic logic [CFG_W-1:0] ident_bases(input int first);
        logic [CFG_W-1:0] r;
        r = '0;
        for (int i = 0; i < SEG_PER_REG; i++) begin
            r[i*SEG_W +: SEG_W] = SEG_W'(first + i);
        end
        return r;
    endfunction

endpackage

// File: rtl/segx_cfg.sv
module segx_cfg
    import segx_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            mode_we,
    input  logic [NUM_SEG-1:0]              mode_wdata,
    input  logic                            base_hi_we,
    input  logic                            base_lo_we,
    input  logic [CFG_W-1:0]                base_wdata,
    output logic [NUM_SEG-1:0]              seg_paged,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_base
);

    logic [NUM_SEG-1:0] mode_q;
    logic [CFG_W-1:0]   lo_q;
    logic [CFG_W-1:0]   hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            lo_q   <= ident_bases(0);
            hi_q   <= ident_bases(SEG_PER_REG);
        end else begin
            if (mode_we)    mode_q <= mode_wdata;
            if (base_lo_we) lo_q   <= base_wdata;
            if (base_hi_we) hi_q   <= base_wdata;
        end
    end

    assign seg_paged = mode_q;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_base
        if (s < SEG_PER_REG) begin : g_lo
            assign seg_base[s] = lo_q[s*SEG_W +: SEG_W];
        end else begin : g_hi
            assign seg_base[s] = hi_q[(s-SEG_PER_REG)*SEG_W +: SEG_W];
        end
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> seg_paged == $past(mode_wdata)); // R3

    AST_BASE_F_LOAD: assert property (@(posedge clk) disable iff (rst)
        base_hi_we |=> seg_base[NUM_SEG-1] == $past(base_wdata[CFG_W-1 -: SEG_W])); // R2

endmodule

// File: rtl/segx_decode.sv
module segx_decode
    import segx_pkg::*;
(
    input  logic [VA_W-1:0]                 vaddr,
    input  logic                            user,
    input  logic [NUM_SEG-1:0]              seg_paged,
    input  logic [NUM_SEG-1:0][SEG_W-1:0]   seg_base,
    output xres_t                           res
);

    logic [SEG_W-1:0] seg;
    logic             in_null_page;

    assign seg          = vaddr[VA_W-1 -: SEG_W];
    assign in_null_page = (vaddr[VA_W-1:PAGE_W] == '0);

    always_comb begin
        res.kind  = XK_LINEAR;
        res.cause = FC_NONE;
        res.paddr = {seg_base[seg], vaddr[OFS_W-1:0]};
        if (user && (seg >= USER_LIMIT_SEG)) begin
            res.kind  = XK_FAULT;
            res.cause = FC_CEILING;
            res.paddr = '0;
        end else if (seg_paged[seg]) begin
            if (in_null_page) begin
                res.kind  = XK_FAULT;
                res.cause = FC_NULLPG;
                res.paddr = '0;
            end else begin
                res.kind  = XK_PAGED;
                res.paddr = vaddr;
            end
        end
    end

endmodule

// File: rtl/segx_pager.sv
module segx_pager
    import segx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc,
    input  xres_t              dec,
    output logic               in_ready,
    input  logic               walk_hit,
    input  logic               walk_miss,
    input  logic [PPN_W-1:0]   walk_ppn,
    output logic               walk_req,
    output logic [VA_W-1:0]    walk_vaddr,
    output logic               res_valid,
    output logic [VA_W-1:0]    res_paddr,
    output logic               res_fault,
    output fcause_e            res_cause
);

    pg_state_e state_q;

    assign in_ready = (state_q == PG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PG_IDLE;
            walk_req   <= 1'b0;
            walk_vaddr <= '0;
            res_valid  <= 1'b0;
            res_paddr  <= '0;
            res_fault  <= 1'b0;
            res_cause  <= FC_NONE;
        end else begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_cause <= FC_NONE;
            case (state_q)
                PG_IDLE: begin
                    if (acc) begin
                        case (dec.kind)
                            XK_PAGED: begin
                                walk_req   <= 1'b1;
                                walk_vaddr <= dec.paddr;
                                state_q    <= PG_WAIT;
                            end
                            XK_FAULT: begin
                                res_valid <= 1'b1;
                                res_fault <= 1'b1;
                                res_cause <= dec.cause;
                                res_paddr <= '0;
                            end
                            default: begin
                                res_valid <= 1'b1;
                                res_paddr <= dec.paddr;
                            end
                        endcase
                    end
                end
                PG_WAIT: begin
                    if (walk_hit) begin
                        res_valid <= 1'b1;
                        res_paddr <= {walk_ppn, walk_vaddr[PAGE_W-1:0]};
                        walk_req  <= 1'b0;
                        state_q   <= PG_IDLE;
                    end else if (walk_miss) begin
                        res_valid <= 1'b1;
                        res_fault <= 1'b1;
                        res_cause <= FC_MISS;
                        res_paddr <= '0;
                        walk_req  <= 1'b0;
                        state_q   <= PG_IDLE;
                    end
                end
                default: state_q <= PG_IDLE;
            endcase
        end
    end

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_hit && !walk_miss) |=> walk_req && $stable(walk_vaddr)); // R7

    AST_NO_ACCEPT_IN_WALK: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !in_ready); // R7

    AST_HIT_RESULT: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_hit) |=> res_valid && !res_fault && !walk_req &&
            res_paddr == {$past(walk_ppn), $past(walk_vaddr[PAGE_W-1:0])}); // R8

    AST_MISS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_miss && !walk_hit) |=> res_valid && res_fault && res_cause == FC_MISS); // R9

    AST_FAULT_ONLY_IN_RESULT: assert property (@(posedge clk) disable iff (rst)
        res_fault |-> res_valid && res_paddr == '0); // R10

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import segx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_we,
    input  logic [15:0]        mode_wdata,
    input  logic               base_hi_we,
    input  logic               base_lo_we,
    input  logic [31:0]        base_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_vaddr,
    input  logic               req_user,
    output logic               res_valid,
    output logic [31:0]        res_paddr,
    output logic               res_fault,
    output logic [1:0]         res_cause,
    output logic               walk_req,
    output logic [31:0]        walk_vaddr,
    input  logic               walk_hit,
    input  logic [18:0]        walk_ppn,
    input  logic               walk_miss
);

    logic [NUM_SEG-1:0]             seg_paged;
    logic [NUM_SEG-1:0][SEG_W-1:0]  seg_base;
    xres_t                          dec;
    fcause_e                        cause;
    logic                           acc;

    assign acc = req_valid && req_ready;

    segx_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .base_hi_we (base_hi_we),
        .base_lo_we (base_lo_we),
        .base_wdata (base_wdata),
        .seg_paged  (seg_paged),
        .seg_base   (seg_base)
    );

    segx_decode u_dec (
        .vaddr     (req_vaddr),
        .user      (req_user),
        .seg_paged (seg_paged),
        .seg_base  (seg_base),
        .res       (dec)
    );

    segx_pager u_pg (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .dec        (dec),
        .in_ready   (req_ready),
        .walk_hit   (walk_hit),
        .walk_miss  (walk_miss),
        .walk_ppn   (walk_ppn),
        .walk_req   (walk_req),
        .walk_vaddr (walk_vaddr),
        .res_valid  (res_valid),
        .res_paddr  (res_paddr),
        .res_fault  (res_fault),
        .res_cause  (cause)
    );

    assign res_cause = cause;

    AST_USER_CEILING: assert property (@(posedge clk) disable iff (rst)
        (acc && req_user && req_vaddr[VA_W-1 -: SEG_W] >= USER_LIMIT_SEG)
            |=> res_valid && res_fault && res_cause == 2'd1); // R5

    AST_LINEAR_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (acc && !(req_user && req_vaddr[VA_W-1 -: SEG_W] >= USER_LIMIT_SEG) &&
         !seg_paged[req_vaddr[VA_W-1 -: SEG_W]])
            |=> res_valid && !res_fault &&
                res_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])); // R1

    AST_NULL_PAGE: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_user && seg_paged[0] && req_vaddr < 32'h2000)
            |=> res_fault && res_cause == 2'd2 && !walk_req); // R6

    AST_WALK_START: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_user && seg_paged[req_vaddr[VA_W-1 -: SEG_W]] && req_vaddr >= 32'h2000)
            |=> walk_req && walk_vaddr == $past(req_vaddr) && !res_valid); // R7

endmodule

// File: tb/seg_xlat_tb.sv
module seg_xlat_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic        base_hi_we = 1'b0;
    logic        base_lo_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic [1:0]  res_cause;
    logic        walk_req;
    logic [31:0] walk_vaddr;
    logic        walk_hit = 1'b0;
    logic [18:0] walk_ppn = '0;
    logic        walk_miss = 1'b0;

    always #4 clk = ~clk;

    seg_xlat u_dut (
        .clk(clk), .rst(rst),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .base_hi_we(base_hi_we), .base_lo_we(base_lo_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_user(req_user),
        .res_valid(res_valid), .res_paddr(res_paddr),
        .res_fault(res_fault), .res_cause(res_cause),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .walk_hit(walk_hit), .walk_ppn(walk_ppn), .walk_miss(walk_miss)
    );

    // behavioural reference model
    int          m_mode [16];
    int          m_base [16];
    bit          m_wait;
    logic [31:0] m_va;
    bit          e_valid, e_fault, e_walk;
    int          e_cause;
    logic [31:0] e_paddr, e_walk_va;
    bit          armed = 0;
    string       phase_req = "R10";
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    always @(posedge clk) begin
        armed = 1;
        if (rst) begin
            for (int s = 0; s < 16; s++) begin
                m_mode[s] = 0;
                m_base[s] = s;
            end
            m_wait = 0; e_valid = 0; e_fault = 0; e_cause = 0; e_walk = 0;
        end else begin
            e_valid = 0; e_fault = 0; e_cause = 0;
            if (!m_wait) begin
                if (req_valid) begin
                    int seg;
                    seg = int'(req_vaddr[31:28]);
                    if (req_user && seg >= 11) begin
                        e_valid = 1; e_fault = 1; e_cause = 1; e_paddr = 0;
                    end else if (m_mode[seg] != 0 && req_vaddr < 32'h2000) begin
                        e_valid = 1; e_fault = 1; e_cause = 2; e_paddr = 0;
                    end else if (m_mode[seg] == 0) begin
                        e_valid = 1;
                        e_paddr = {4'(m_base[seg]), req_vaddr[27:0]};
                    end else begin
                        m_wait = 1; m_va = req_vaddr; e_walk_va = req_vaddr;
                    end
                end
            end else if (walk_hit) begin
                e_valid = 1; e_paddr = {walk_ppn, m_va[12:0]}; m_wait = 0;
            end else if (walk_miss) begin
                e_valid = 1; e_fault = 1; e_cause = 3; e_paddr = 0; m_wait = 0;
            end
            e_walk = m_wait;
            if (mode_we)
                for (int s = 0; s < 16; s++) m_mode[s] = int'(mode_wdata[s]);
            if (base_lo_we)
                for (int s = 0; s < 8; s++) m_base[s] = int'(base_wdata[4*s +: 4]);
            if (base_hi_we)
                for (int s = 0; s < 8; s++) m_base[8+s] = int'(base_wdata[4*s +: 4]);
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            bit bad;
            bad = 0;
            vectors++;
            if (req_ready !== !m_wait) begin
                bad = 1;
                $display("FAIL %s req_ready actual %b expected %b", phase_req, req_ready, !m_wait);
            end
            if (res_valid !== e_valid) begin
                bad = 1;
                $display("FAIL %s res_valid actual %b expected %b", phase_req, res_valid, e_valid);
            end
            if (res_fault !== e_fault || res_cause !== 2'(e_cause)) begin
                bad = 1;
                $display("FAIL %s fault/cause actual %b/%0d expected %b/%0d",
                         phase_req, res_fault, res_cause, e_fault, e_cause);
            end
            if (e_valid && res_paddr !== e_paddr) begin
                bad = 1;
                $display("FAIL %s res_paddr actual %h expected %h", phase_req, res_paddr, e_paddr);
            end
            if (walk_req !== e_walk) begin
                bad = 1;
                $display("FAIL %s walk_req actual %b expected %b", phase_req, walk_req, e_walk);
            end
            if (e_walk && walk_vaddr !== e_walk_va) begin
                bad = 1;
                $display("FAIL %s walk_vaddr actual %h expected %h", phase_req, walk_vaddr, e_walk_va);
            end
            if (bad) miscompares++;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // send one request; answer a lookup if the model shows one outstanding
    task automatic send(input logic [31:0] va, input bit user, input string tag,
                        input bit miss, input logic [18:0] ppn, input int delay);
        @(negedge clk);
        phase_req = tag;
        req_valid = 1; req_vaddr = va; req_user = user;
        @(negedge clk);
        req_valid = 0;
        if (m_wait) begin
            repeat (delay) @(negedge clk);
            walk_hit = !miss; walk_miss = miss; walk_ppn = ppn;
            @(negedge clk);
            walk_hit = 0; walk_miss = 0;
        end
    endtask

    task automatic load(input bit is_mode, input bit hi, input logic [31:0] d);
        @(negedge clk);
        if (is_mode) begin mode_we = 1; mode_wdata = d[15:0]; end
        else if (hi) begin base_hi_we = 1; base_wdata = d; end
        else begin base_lo_we = 1; base_wdata = d; end
        @(negedge clk);
        mode_we = 0; base_hi_we = 0; base_lo_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired, run hung");
            finish_run();
        end
    end

    initial begin
        phase_req = "R10";
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        // R4: identity mapping out of reset
        send(32'h1234_5678, 0, "R4", 0, 0, 0);
        send(32'hFEDC_BA98, 0, "R4", 0, 0, 0);
        send(32'h0000_0000, 0, "R4", 0, 0, 0);

        // R11: load at the same edge as an accepted request
        @(negedge clk);
        phase_req = "R11";
        base_hi_we = 1; base_wdata = 32'h0804_B000;
        req_valid = 1; req_vaddr = 32'hC000_1000; req_user = 0;
        @(negedge clk);
        base_hi_we = 0; req_valid = 0;
        send(32'hC000_1000, 0, "R11", 0, 0, 0);

        // R2 / R3: reference configuration
        load(0, 0, 32'h0000_0000);
        load(1, 0, 32'h0000_27FF);
        send(32'hC000_1000, 0, "R1", 0, 0, 0);
        send(32'hB000_0010, 0, "R2", 0, 0, 0);
        send(32'hE123_4567, 0, "R2", 0, 0, 0);
        send(32'hF765_4321, 0, "R2", 0, 0, 0);

        // R5: user ceiling
        send(32'hB000_0000, 1, "R5", 0, 0, 0);
        send(32'hC000_1000, 1, "R5", 0, 0, 0);
        send(32'hD004_000C, 1, "R5", 0, 0, 0);
        send(32'hAFFF_FFFF, 1, "R5", 0, 19'h00ABC, 1);

        // R6: null page
        send(32'h0000_1FFF, 0, "R6", 0, 0, 0);
        send(32'h0000_0000, 1, "R6", 0, 0, 0);
        send(32'h0000_2000, 0, "R6", 0, 19'h7FFFF, 0);

        // R7 / R8 / R9: lookup
        send(32'hD004_000C, 0, "R8", 0, 19'h12345, 3);
        send(32'h5000_0ABC, 1, "R9", 1, 0, 2);
        @(negedge clk);
        phase_req = "R8";
        req_valid = 1; req_vaddr = 32'h3000_4444; req_user = 0;
        @(negedge clk);
        req_valid = 0;
        walk_hit = 1; walk_miss = 1; walk_ppn = 19'h0F0F0;
        @(negedge clk);
        walk_hit = 0; walk_miss = 0;

        // R7: stray responses while idle are ignored
        @(negedge clk);
        phase_req = "R7";
        walk_hit = 1; walk_ppn = 19'h1;
        @(negedge clk);
        walk_hit = 0; walk_miss = 1;
        @(negedge clk);
        walk_miss = 0;

        // R7: request held against low ready is accepted once, later
        @(negedge clk);
        req_valid = 1; req_vaddr = 32'h7000_8000; req_user = 0;
        @(negedge clk);
        req_vaddr = 32'hC111_2222;
        repeat (3) @(negedge clk);
        walk_hit = 1; walk_ppn = 19'h00042;
        @(negedge clk);
        walk_hit = 0;
        @(negedge clk);
        req_valid = 0;

        // R10: back-to-back linear requests
        @(negedge clk);
        phase_req = "R10";
        req_valid = 1; req_vaddr = 32'hC000_0004; req_user = 0;
        @(negedge clk);
        req_vaddr = 32'hE000_0008;
        @(negedge clk);
        req_vaddr = 32'hB000_0000; req_user = 1;
        @(negedge clk);
        req_valid = 0; req_user = 0;
        repeat (2) @(negedge clk);

        // R1: random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] va;
            va = $urandom;
            if (($urandom % 8) == 0) va[31:13] = '0;
            if (($urandom % 40) == 0) load(1, 0, $urandom);
            if (($urandom % 60) == 0) load(0, ($urandom % 2) == 1, $urandom);
            send(va, ($urandom % 2) == 1, "R1", ($urandom % 3) == 0,
                 19'($urandom), int'($urandom % 4));
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule